// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Controller

This block is the digital front end of a two-channel converter. It takes 16-bit words from a three-wire serial link: an active-low frame select, a serial clock, and a data line. Each word carries a target channel, a reference-buffer choice, a two-bit power-down code, and a straight-binary data field. A completed word lands in that channel's input register. The power-down and reference settings for the channel are taken at the same moment.

A separate active-low update strobe copies both input registers into the DAC registers together, so the two outputs can change in one cycle. All four link inputs are asynchronous to the system clock. Each passes through a multi-flop synchronizer, and serial clock falling edges are detected in the system clock domain. The serial clock must therefore run well below the system clock.

Top module: `dualdac_ctrl`

## Requirements
- R1: A word is built from the data-line value at each serial clock falling edge while frame select is low, first bit received becoming bit 15. It is accepted when frame select returns high.
- R2: Word bits 13:12 are the power-down code of the addressed channel, shown on its two-bit power-down output. 00 is normal operation; 01, 10 and 11 pick the three powered-down output loads.
- R3: Word bit 15 picks the channel (0 = A, 1 = B). The other channel's input register, power-down code and reference setting are untouched.
- R4: The DATA_W bits directly below bit 12, most significant first, form the channel code in straight binary. With DATA_W = 8 that is bits 11:4, and bits 3:0 have no effect.
- R5: A frame with fewer or more than 16 falling edges before frame select rises changes no register and no output.
- R6: While the synchronized update strobe is low, both DAC registers load their input registers on every cycle. While it is high, both DAC codes hold.
- R7: After reset both codes are zero, both power-down codes are 00, and both reference settings are unbuffered (0).
- R8: Word bit 14 sets the addressed channel's reference-buffer output (1 = buffered). It is applied when the frame is accepted, whatever the update strobe does.
- R9: Frame select held low across two bursts of 8 edges with an idle gap between them still gives one valid frame.
- R10: A frame accepted while the update strobe is held low reaches the DAC code one cycle after the input register, with no further strobe activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame select, asynchronous |
| ser_clk | input | 1 | Serial clock, data taken on falling edge, asynchronous |
| ser_din | input | 1 | Serial data line |
| update_n | input | 1 | Active-low level update strobe, asynchronous |
| code_a | output | DATA_W | Channel A DAC register |
| code_b | output | DATA_W | Channel B DAC register |
| pwrdn_a | output | 2 | Channel A power-down code |
| pwrdn_b | output | 2 | Channel B power-down code |
| refbuf_a | output | 1 | Channel A reference buffered when 1 |
| refbuf_b | output | 1 | Channel B reference buffered when 1 |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 2. The 8-bit field leaves four trailing frame bits that must be ignored, so stuffing them with ones tests R4 directly. The two-stage synchronizer fixes a known latency that the bench's queue-based model reproduces on every cycle. With the serial clock held for three system cycles per phase, the same settings cover short, long and split frames, and they cover writes made while the strobe is held low.

// File: rtl/dualdac_pkg.sv
package dualdac_pkg;

    localparam int FRAME_W   = 16;
    localparam int NUM_CH    = 2;
    localparam int CH_BIT    = 15;
    localparam int BUF_BIT   = 14;
    localparam int PD_MSB    = 13;
    localparam int PD_LSB    = 12;
    localparam int FIELD_MSB = 11;
    localparam int FIELD_W   = FIELD_MSB + 1;

    typedef enum logic [1:0] {
        PD_ACTIVE    = 2'b00,
        PD_LOAD_LOW  = 2'b01,
        PD_LOAD_HIGH = 2'b10,
        PD_FLOAT     = 2'b11
    } pd_mode_e;

    typedef struct packed {
        logic               chan;
        logic               refbuf;
        pd_mode_e           pd;
        logic [FIELD_W-1:0] field;
    } frame_t;

    function automatic frame_t unpack_frame(input logic [FRAME_W-1:0] w);
        frame_t f;
        f.chan   = w[CH_BIT];
        f.refbuf = w[BUF_BIT];
        f.pd     = pd_mode_e'(w[PD_MSB:PD_LSB]);
        f.field  = w[FIELD_MSB:0];
        return f;
    endfunction

endpackage

// File: rtl/dualdac_sync.sv
module dualdac_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= RST_VAL;
        else     pipe[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[g] <= RST_VAL;
            else     pipe[g] <= pipe[g-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dualdac_rx.sv
module dualdac_rx
    import dualdac_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frm_s,
    input  logic          sclk_s,
    input  logic          sdi_s,
    output logic          frame_valid,
    output logic [FW-1:0] frame_word
);
    localparam int             CW       = $clog2(FW + 2);
    localparam logic [CW-1:0]  CNT_FULL = CW'(FW);
    localparam logic [CW-1:0]  CNT_OVER = CW'(FW + 1);

    logic          frm_d;
    logic          sclk_d;
    logic [CW-1:0] edge_cnt;
    logic [FW-1:0] shreg;
    logic          clk_fall;
    logic          frm_rise;

    assign clk_fall = sclk_d & ~sclk_s;
    assign frm_rise = ~frm_d & frm_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_d    <= 1'b1;
            sclk_d   <= 1'b0;
            edge_cnt <= '0;
            shreg    <= '0;
        end else begin
            frm_d  <= frm_s;
            sclk_d <= sclk_s;
            if (frm_s) begin
                edge_cnt <= '0;
            end else if (clk_fall) begin
                shreg    <= {shreg[FW-2:0], sdi_s};
                edge_cnt <= (edge_cnt == CNT_OVER) ? edge_cnt : edge_cnt + 1'b1;
            end
        end
    end

    assign frame_valid = frm_rise && (edge_cnt == CNT_FULL);
    assign frame_word  = shreg;
endmodule

// File: rtl/dualdac_bank.sv
module dualdac_bank
    import dualdac_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_valid,
    input  logic [FRAME_W-1:0]            frame_word,
    input  logic                          upd_s,
    output logic [NUM_CH-1:0][DW-1:0]     in_q,
    output logic [NUM_CH-1:0][DW-1:0]     dac_q,
    output logic [NUM_CH-1:0][1:0]        pd_q,
    output logic [NUM_CH-1:0]             buf_q
);
    frame_t        fr;
    logic [DW-1:0] code_new;

    assign fr       = unpack_frame(frame_word);
    assign code_new = fr.field[FIELD_W-1 -: DW];

    if (DW < FIELD_W) begin : g_trim
        logic unused_tail;
        assign unused_tail = ^fr.field[FIELD_W-DW-1:0];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic          sel;
        logic [DW-1:0] in_r;
        logic [DW-1:0] dac_r;
        logic [1:0]    pd_r;
        logic          buf_r;

        assign sel = frame_valid && (fr.chan == 1'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                in_r  <= '0;
                dac_r <= '0;
                pd_r  <= PD_ACTIVE;
                buf_r <= 1'b0;
            end else begin
                if (sel) begin
                    in_r  <= code_new;
                    pd_r  <= fr.pd;
                    buf_r <= fr.refbuf;
                end
                if (!upd_s) dac_r <= in_r;
            end
        end

        assign in_q[g]  = in_r;
        assign dac_q[g] = dac_r;
        assign pd_q[g]  = pd_r;
        assign buf_q[g] = buf_r;
    end
endmodule

// File: rtl/dualdac_ctrl.sv
module dualdac_ctrl
    import dualdac_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              update_n,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic [1:0]        pwrdn_a,
    output logic [1:0]        pwrdn_b,
    output logic              refbuf_a,
    output logic              refbuf_b
);
    localparam logic [3:0] IDLE_LEVELS = 4'b1100;

    logic [3:0]                     sync_bus;
    logic                           upd_s;
    logic                           frm_s;
    logic                           sclk_s;
    logic                           sdi_s;
    logic                           frame_valid;
    logic [FRAME_W-1:0]             frame_word;
    logic [NUM_CH-1:0][DATA_W-1:0]  in_q;
    logic [NUM_CH-1:0][DATA_W-1:0]  dac_q;
    logic [NUM_CH-1:0][1:0]         pd_q;
    logic [NUM_CH-1:0]              buf_q;

    dualdac_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_LEVELS)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({update_n, frame_n, ser_clk, ser_din}),
        .q   (sync_bus)
    );

    assign upd_s  = sync_bus[3];
    assign frm_s  = sync_bus[2];
    assign sclk_s = sync_bus[1];
    assign sdi_s  = sync_bus[0];

    dualdac_rx #(.FW(FRAME_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .frm_s       (frm_s),
        .sclk_s      (sclk_s),
        .sdi_s       (sdi_s),
        .frame_valid (frame_valid),
        .frame_word  (frame_word)
    );

    dualdac_bank #(.DW(DATA_W)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (frame_valid),
        .frame_word  (frame_word),
        .upd_s       (upd_s),
        .in_q        (in_q),
        .dac_q       (dac_q),
        .pd_q        (pd_q),
        .buf_q       (buf_q)
    );

    assign code_a   = dac_q[0];
    assign code_b   = dac_q[1];
    assign pwrdn_a  = pd_q[0];
    assign pwrdn_b  = pd_q[1];
    assign refbuf_a = buf_q[0];
    assign refbuf_b = buf_q[1];
endmodule

// File: rtl/dualdac_chk.sv
module dualdac_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          frame_valid,
    input logic [15:0]   frame_word,
    input logic          upd_s,
    input logic [DW-1:0] in_a,
    input logic [DW-1:0] in_b,
    input logic [DW-1:0] code_a,
    input logic [DW-1:0] code_b,
    input logic [1:0]    pwrdn_a,
    input logic [1:0]    pwrdn_b,
    input logic          refbuf_a,
    input logic          refbuf_b
);
    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code_a == '0 && code_b == '0 && pwrdn_a == 2'b00 &&
                        pwrdn_b == 2'b00 && !refbuf_a && !refbuf_b));

    assert_hold_codes_R6: assert property (@(posedge clk) disable iff (rst)
        upd_s |=> ($stable(code_a) && $stable(code_b)));

    assert_copy_both_R6: assert property (@(posedge clk) disable iff (rst)
        !upd_s |=> (code_a == $past(in_a) && code_b == $past(in_b)));

    assert_no_frame_no_change_R5: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |=> ($stable(in_a) && $stable(in_b) && $stable(pwrdn_a) &&
                          $stable(pwrdn_b) && $stable(refbuf_a) && $stable(refbuf_b)));

    assert_a_spares_b_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && !frame_word[15]) |=> ($stable(in_b) && $stable(pwrdn_b) && $stable(refbuf_b)));

    assert_b_spares_a_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && frame_word[15]) |=> ($stable(in_a) && $stable(pwrdn_a) && $stable(refbuf_a)));

    assert_cfg_b_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && frame_word[15]) |=> (refbuf_b == $past(frame_word[14]) &&
                                             pwrdn_b == $past(frame_word[13:12])));

    assert_cfg_a_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && !frame_word[15]) |=> (refbuf_a == $past(frame_word[14]) &&
                                              pwrdn_a == $past(frame_word[13:12])));

    assert_data_field_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && !frame_word[15]) |=> (in_a == $past(frame_word[11 -: DW])));
endmodule

bind dualdac_ctrl dualdac_chk #(.DW(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_valid (frame_valid),
    .frame_word  (frame_word),
    .upd_s       (upd_s),
    .in_a        (in_q[0]),
    .in_b        (in_q[1]),
    .code_a      (code_a),
    .code_b      (code_b),
    .pwrdn_a     (pwrdn_a),
    .pwrdn_b     (pwrdn_b),
    .refbuf_a    (refbuf_a),
    .refbuf_b    (refbuf_b)
);

// File: tb/sim_dualdac_ctrl.sv
`timescale 1ns/1ps
module sim_dualdac_ctrl;
    localparam int DW   = 8;
    localparam int SYNC = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_n = 1'b1;
    logic          ser_clk = 1'b1;
    logic          ser_din = 1'b0;
    logic          update_n = 1'b1;
    logic [DW-1:0] code_a, code_b;
    logic [1:0]    pwrdn_a, pwrdn_b;
    logic          refbuf_a, refbuf_b;

    int n_chk = 0;
    int n_err = 0;

    dualdac_ctrl #(.DATA_W(DW), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst(rst), .frame_n(frame_n), .ser_clk(ser_clk),
        .ser_din(ser_din), .update_n(update_n), .code_a(code_a), .code_b(code_b),
        .pwrdn_a(pwrdn_a), .pwrdn_b(pwrdn_b), .refbuf_a(refbuf_a), .refbuf_b(refbuf_b)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: queues model the input delay, integers the state
    bit q_frm[$], q_clk[$], q_din[$], q_upd[$];
    int m_cnt;
    bit [15:0] m_word;
    int m_in[2], m_dac[2], m_pd[2], m_buf[2];
    bit s_frm, p_frm, s_clk, p_clk, s_din, s_upd;
    int ch;

    always @(posedge clk) begin
        if (rst) begin
            q_frm.delete(); q_clk.delete(); q_din.delete(); q_upd.delete();
            for (int i = 0; i < SYNC + 1; i++) begin
                q_frm.push_back(1'b1); q_clk.push_back(1'b0);
                q_din.push_back(1'b0); q_upd.push_back(1'b1);
            end
            m_cnt = 0; m_word = '0;
            for (int i = 0; i < 2; i++) begin
                m_in[i] = 0; m_dac[i] = 0; m_pd[i] = 0; m_buf[i] = 0;
            end
        end else begin
            s_frm = q_frm[SYNC-1]; p_frm = q_frm[SYNC];
            s_clk = q_clk[SYNC-1]; p_clk = q_clk[SYNC];
            s_din = q_din[SYNC-1]; s_upd = q_upd[SYNC-1];
            if (!s_upd) begin
                m_dac[0] = m_in[0]; m_dac[1] = m_in[1];
            end
            if (!p_frm && s_frm && m_cnt == 16) begin
                ch = int'(m_word[15]);
                m_in[ch]  = int'(m_word[11 -: DW]);
                m_pd[ch]  = int'(m_word[13:12]);
                m_buf[ch] = int'(m_word[14]);
            end
            if (s_frm) m_cnt = 0;
            else if (p_clk && !s_clk) begin
                m_word = {m_word[14:0], s_din};
                if (m_cnt < 17) m_cnt++;
            end
            q_frm.push_front(frame_n);  void'(q_frm.pop_back());
            q_clk.push_front(ser_clk);  void'(q_clk.pop_back());
            q_din.push_front(ser_din);  void'(q_din.pop_back());
            q_upd.push_front(update_n); void'(q_upd.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(32'(code_a),   32'(m_dac[0]), "R6/R4 model code_a");
            chk(32'(code_b),   32'(m_dac[1]), "R6/R4 model code_b");
            chk(32'(pwrdn_a),  32'(m_pd[0]),  "R2 model pwrdn_a");
            chk(32'(pwrdn_b),  32'(m_pd[1]),  "R2 model pwrdn_b");
            chk(32'(refbuf_a), 32'(m_buf[0]), "R8 model refbuf_a");
            chk(32'(refbuf_b), 32'(m_buf[1]), "R8 model refbuf_b");
        end
    end

    task automatic send_bits(input logic [15:0] w, input int n, input int gap);
        @(negedge clk) frame_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (gap != 0 && i == gap) repeat (20) @(negedge clk);
            ser_din = (i < 16) ? w[15-i] : 1'b0;
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        ser_clk = 1'b1;
        repeat (2) @(negedge clk);
        frame_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic pulse_update();
        update_n = 1'b0;
        repeat (3) @(negedge clk);
        update_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk(32'(code_a), 0, "R7 code_a");
        chk(32'(code_b), 0, "R7 code_b");
        chk(32'(pwrdn_a), 0, "R7 pwrdn_a");
        chk(32'(refbuf_b), 0, "R7 refbuf_b");

        // channel A, buffered, normal, data A5, trailing bits all ones
        send_bits(16'h4A5F, 16, 0);
        chk(32'(refbuf_a), 1, "R8 refbuf_a before strobe");
        chk(32'(code_a), 0, "R6 code_a holds without strobe");
        pulse_update();
        chk(32'(code_a), 32'hA5, "R1 R4 code_a msb-first, tail ignored");
        chk(32'(code_b), 0, "R3 code_b untouched");

        // channel B, power-down 10, data 3C
        send_bits(16'hA3C0, 16, 0);
        chk(32'(pwrdn_b), 2, "R2 pwrdn_b");
        chk(32'(pwrdn_a), 0, "R3 pwrdn_a untouched");
        chk(32'(code_b), 0, "R6 code_b holds");

        // short frame: 10 edges
        send_bits(16'h7FFF, 10, 0);
        chk(32'(pwrdn_a), 0, "R5 short frame pwrdn_a");
        chk(32'(refbuf_a), 1, "R5 short frame refbuf_a");
        pulse_update();
        chk(32'(code_a), 32'hA5, "R5 short frame code_a");
        chk(32'(code_b), 32'h3C, "R6 both channels loaded together");

        // long frame: 17 edges
        send_bits(16'h3FF0, 17, 0);
        chk(32'(pwrdn_a), 0, "R5 long frame pwrdn_a");
        chk(32'(refbuf_a), 1, "R5 long frame refbuf_a");

        // split frame: two bursts of 8 with a pause
        send_bits(16'h1FF0, 16, 8);
        chk(32'(pwrdn_a), 1, "R9 split frame pwrdn_a");
        chk(32'(refbuf_a), 0, "R8 split frame refbuf_a");

        // strobe held low
        update_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(32'(code_a), 32'hFF, "R9 split frame data");
        send_bits(16'h4000, 16, 0);
        chk(32'(code_a), 0, "R10 write under low strobe code_a");
        chk(32'(refbuf_a), 1, "R8 refbuf_a under low strobe");
        send_bits(16'h8810, 16, 0);
        chk(32'(code_b), 32'h81, "R10 write under low strobe code_b");
        update_n = 1'b1;
        repeat (4) @(negedge clk);
        send_bits(16'h8FF0, 16, 0);
        chk(32'(code_b), 32'h81, "R6 code_b holds after strobe release");

        summary();
        $finish;
    end
endmodule